// File: doc/BRIEF.md
# Guarded Mode Configuration Register Slave

This block is the register front end of a peripheral. It sits on a simple synchronous 16-bit bus and holds a configuration word with three live fields:
- an unlock bit;
- an operating-mode bit that picks legacy or enhanced operation;
- a privilege bit that decides who may touch the assignable part of the address window.

The mode bit can be rewritten only while the unlock bit is already set. A mode change therefore takes three writes: unlock, write the new mode, then relock while writing the same mode value.

Every access is screened before it takes effect. The screen looks at three things: whether the bus master is in supervisor mode, which region the offset falls in, and the privilege bit. The regions are supervisor-only, assignable and unimplemented. A refused access raises the error output in the same cycle as the strobe. A refused read returns zero, and a refused write changes nothing. The assignable region holds a set of general scratch words. The selected operating mode is driven out continuously for the rest of the peripheral.

Top module: `cfg_guard_top`

## Requirements
- R1: After reset the configuration word reads 0x0080 (unlock 0, mode 0, privilege 1), every scratch word reads 0x0000, and `enhancedMode` is 0.
- R2: In the configuration word, bit 9 is the unlock bit, bit 8 is the mode bit and bit 7 is the privilege bit. All other bits read as 0, and writes to them are ignored.
- R3: A permitted write to the configuration word updates the mode bit only if the unlock bit was already 1 before that write. Otherwise the mode bit keeps its value, while the unlock and privilege bits always take the written values.
- R4: The three-write sequence switches the mode in both directions: 0x0280, 0x0380, 0x0180 for legacy to enhanced, and 0x0280, 0x0280, 0x0080 for enhanced to legacy. `enhancedMode` shows the mode bit from the clock edge that ends the updating write.
- R5: The configuration word sits at offset 0 and is supervisor-only. A user read raises `busErr` and returns 0. A user write raises `busErr` and leaves the word unchanged.
- R6: Offsets 1 to NUM_SCRATCH hold the scratch words, which form the assignable region. With privilege 1, user reads and writes are refused in the same way as in R5. With privilege 0, user reads and writes are carried out without error.
- R7: Any read or write to an offset above NUM_SCRATCH raises `busErr`, whatever the privilege of the access. A read returns 0, and a write leaves the configuration and scratch words unchanged.
- R8: `busErr` is high only in a cycle where `rdEn` or `wrEn` is high. `rdData` is 0 whenever there is no permitted read.
- R9: A supervisor access to an implemented offset never raises `busErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word offset inside the block's window |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| isSuper | input | 1 | 1 when the access is made in supervisor mode |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data, valid in the strobe cycle |
| busErr | output | 1 | Access refused, in the strobe cycle |
| enhancedMode | output | 1 | 1 selects enhanced operation, 0 selects legacy |

## Verification
The error flag and read data depend only on the inputs and the stored state in the same cycle, so they are due in the strobe cycle itself. A write's effect is due only after the next rising edge, both on a later read and on `enhancedMode`. The bench drives each access on a falling edge and queues the expected error, data and mode. The monitor compares them a quarter period later, before the rising edge that commits the write. The mode value expected in that comparison is therefore the value from before the write, and each write's result is checked by a following read.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  localparam int DATA_W   = 16;
  localparam int IDX_W    = 4;
  localparam int LOCK_POS = 9;
  localparam int MODE_POS = 8;
  localparam int PRIV_POS = 7;

  typedef enum logic [1:0] {
    REGION_SUPER  = 2'd0,
    REGION_ASSIGN = 2'd1,
    REGION_NONE   = 2'd2
  } region_e;

  typedef struct packed {
    logic             cfgWr;
    logic             cfgRd;
    logic             scrWr;
    logic             scrRd;
    logic [IDX_W-1:0] scrIdx;
  } strobe_t;
endpackage

// File: rtl/cfg_guard_ctrl.sv
module cfg_guard_ctrl
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int NUM_SCRATCH = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              isSuper,
  input  logic              privBit,
  output strobe_t           strobes,
  output logic              accErr
);
  localparam int CFG_OFFSET = 0;
  localparam int SCR_BASE   = 1;
  localparam int SCR_LAST   = SCR_BASE + NUM_SCRATCH - 1;

  logic [31:0] addrWide;
  region_e     region;
  logic        permitted;
  logic        access;

  assign addrWide = 32'(addr);
  assign access   = rdEn | wrEn;

  always_comb begin
    if (addrWide == 32'(CFG_OFFSET))
      region = REGION_SUPER;
    else if (addrWide >= 32'(SCR_BASE) && addrWide <= 32'(SCR_LAST))
      region = REGION_ASSIGN;
    else
      region = REGION_NONE;
  end

  always_comb begin
    unique case (region)
      REGION_SUPER:  permitted = isSuper;
      REGION_ASSIGN: permitted = isSuper | ~privBit;
      default:       permitted = 1'b0;
    endcase
  end

  assign accErr = access & ~permitted;

  always_comb begin
    strobes        = '0;
    strobes.cfgWr  = wrEn & permitted & (region == REGION_SUPER);
    strobes.cfgRd  = rdEn & permitted & (region == REGION_SUPER);
    strobes.scrWr  = wrEn & permitted & (region == REGION_ASSIGN);
    strobes.scrRd  = rdEn & permitted & (region == REGION_ASSIGN);
    strobes.scrIdx = IDX_W'(addrWide - 32'(SCR_BASE));
  end
endmodule

// File: rtl/cfg_guard_dpath.sv
module cfg_guard_dpath
  import cfg_guard_pkg::*;
#(
  parameter int NUM_SCRATCH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              privBit,
  output logic              modeBit
);
  logic lockQ;
  logic modeQ;
  logic privQ;
  logic [NUM_SCRATCH-1:0][DATA_W-1:0] scrFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockQ <= 1'b0;
      modeQ <= 1'b0;
      privQ <= 1'b1;
    end else if (strobes.cfgWr) begin
      lockQ <= wrData[LOCK_POS];
      privQ <= wrData[PRIV_POS];
      if (lockQ) modeQ <= wrData[MODE_POS];
    end
  end

  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : gScr
    logic [DATA_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordQ <= '0;
      else if (strobes.scrWr && strobes.scrIdx == IDX_W'(g))
        wordQ <= wrData;
    end
    assign scrFlat[g] = wordQ;
  end

  always_comb begin
    rdData = '0;
    if (strobes.cfgRd) begin
      rdData[LOCK_POS] = lockQ;
      rdData[MODE_POS] = modeQ;
      rdData[PRIV_POS] = privQ;
    end else if (strobes.scrRd) begin
      for (int i = 0; i < NUM_SCRATCH; i++)
        if (strobes.scrIdx == IDX_W'(i)) rdData = scrFlat[i];
    end
  end

  assign privBit = privQ;
  assign modeBit = modeQ;
endmodule

// File: rtl/cfg_guard_top.sv
module cfg_guard_top
  import cfg_guard_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int NUM_SCRATCH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic              isSuper,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  output logic              busErr,
  output logic              enhancedMode
);
  strobe_t strobes;
  logic    privBit;

  cfg_guard_ctrl #(.ADDR_W(ADDR_W), .NUM_SCRATCH(NUM_SCRATCH)) u_ctrl (
    .addr    (addr),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .isSuper (isSuper),
    .privBit (privBit),
    .strobes (strobes),
    .accErr  (busErr)
  );

  cfg_guard_dpath #(.NUM_SCRATCH(NUM_SCRATCH)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .rdData  (rdData),
    .privBit (privBit),
    .modeBit (enhancedMode)
  );
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int ADDR_W      = 3,
  parameter int NUM_SCRATCH = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              rdEn,
  input logic              wrEn,
  input logic              isSuper,
  input logic [15:0]       rdData,
  input logic              busErr,
  input logic              enhancedMode
);
  // R8
  err_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (rdEn || wrEn));

  // R5
  err_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> rdData == 16'h0000);

  // R7
  unimpl_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn || wrEn) && 32'(addr) > NUM_SCRATCH) |-> busErr);

  // R5
  user_cfg_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn || wrEn) && !isSuper && addr == '0) |-> busErr);

  // R9
  super_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn || wrEn) && isSuper && 32'(addr) <= NUM_SCRATCH) |-> !busErr);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn || !isSuper || addr != '0) |=> $stable(enhancedMode));

  // R8
  idle_rd_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |-> rdData == 16'h0000);
endmodule

bind cfg_guard_top cfg_guard_chk #(.ADDR_W(ADDR_W), .NUM_SCRATCH(NUM_SCRATCH)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .addr         (addr),
  .rdEn         (rdEn),
  .wrEn         (wrEn),
  .isSuper      (isSuper),
  .rdData       (rdData),
  .busErr       (busErr),
  .enhancedMode (enhancedMode)
);

// File: tb/tb_cfg_guard_top.sv
module tb_cfg_guard_top;
  localparam int ADDR_W = 3;
  localparam int NSCR   = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rdEn = 1'b0;
  logic              wrEn = 1'b0;
  logic              isSuper = 1'b0;
  logic [15:0]       wrData = '0;
  logic [15:0]       rdData;
  logic              busErr;
  logic              enhancedMode;

  cfg_guard_top #(.ADDR_W(ADDR_W), .NUM_SCRATCH(NSCR)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .isSuper(isSuper), .wrData(wrData), .rdData(rdData),
    .busErr(busErr), .enhancedMode(enhancedMode)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] expData;
    logic        expErr;
    logic        expMode;
    string       tag;
  } item_t;

  item_t itemQ[$];
  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  // reference state built from the requirements
  logic        mLock = 1'b0, mMode = 1'b0, mPriv = 1'b1;
  logic [15:0] mScr [NSCR];

  task automatic access(input bit rd, input bit wr, input bit sup,
                        input int a, input logic [15:0] d, input string tag);
    item_t it;
    bit ok;
    @(negedge clk);
    addr = ADDR_W'(a); rdEn = rd; wrEn = wr; isSuper = sup; wrData = d;
    if (a == 0) ok = sup;
    else if (a <= NSCR) ok = sup || !mPriv;
    else ok = 1'b0;
    it.expErr  = (rd || wr) && !ok;
    it.expMode = mMode;
    it.tag     = tag;
    it.expData = 16'h0000;
    if (rd && ok) begin
      if (a == 0) it.expData = {6'b0, mLock, mMode, mPriv, 7'b0};
      else it.expData = mScr[a-1];
    end
    itemQ.push_back(it);
    if (wr && ok) begin
      if (a == 0) begin
        if (mLock) mMode = d[8];
        mLock = d[9];
        mPriv = d[7];
      end else mScr[a-1] = d;
    end
    @(posedge clk);
    #1;
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  always begin
    @(negedge clk);
    #5;
    while (itemQ.size() > 0) begin
      item_t it;
      it = itemQ.pop_front();
      checks++;
      if (busErr !== it.expErr || rdData !== it.expData || enhancedMode !== it.expMode) begin
        errors++;
        $display("FAIL %s: err=%b data=%h mode=%b expected err=%b data=%h mode=%b",
                 it.tag, busErr, rdData, enhancedMode, it.expErr, it.expData, it.expMode);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSCR; i++) mScr[i] = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    access(1, 0, 1, 0, 0, "R1 cfg reset");
    access(1, 0, 1, 1, 0, "R1 scratch0 reset");
    access(1, 0, 1, 2, 0, "R1 scratch1 reset");
    // R8 idle cycle
    access(0, 0, 0, 0, 0, "R8 idle");

    // R3 mode write ignored while unlock is 0
    access(0, 1, 1, 0, 16'h0180, "R3 write mode while locked");
    access(1, 0, 1, 0, 0, "R3 readback");

    // R4 legacy to enhanced
    access(0, 1, 1, 0, 16'h0280, "R4 unlock");
    access(0, 1, 1, 0, 16'h0380, "R4 set mode");
    access(0, 1, 1, 0, 16'h0180, "R4 relock");
    access(1, 0, 1, 0, 0, "R4 read enhanced");
    access(0, 1, 1, 0, 16'h0080, "R3 clear mode while locked");
    access(1, 0, 1, 0, 0, "R3 mode kept");
    // R4 enhanced to legacy
    access(0, 1, 1, 0, 16'h0280, "R4 unlock back");
    access(1, 0, 1, 0, 0, "R3 mode kept on unlocking write");
    access(0, 1, 1, 0, 16'h0280, "R4 clear mode");
    access(0, 1, 1, 0, 16'h0080, "R4 relock back");
    access(1, 0, 1, 0, 0, "R4 read legacy");

    // R2 unused bits
    access(0, 1, 1, 0, 16'hFC7F, "R2 write unused bits");
    access(1, 0, 1, 0, 0, "R2 readback zeros");
    access(0, 1, 1, 0, 16'hFFFF, "R2 write all ones");
    access(1, 0, 1, 0, 0, "R2 readback fields");
    access(0, 1, 1, 0, 16'h0080, "R2 restore");

    // R5 user access to the configuration word
    access(1, 0, 0, 0, 0, "R5 user read cfg");
    access(0, 1, 0, 0, 16'h0280, "R5 user write cfg");
    access(1, 0, 1, 0, 0, "R5 cfg unchanged");

    // R6 assignable region with privilege 1
    access(0, 1, 0, 1, 16'h1234, "R6 user write restricted");
    access(1, 0, 1, 1, 0, "R6 scratch unchanged");
    access(0, 1, 1, 1, 16'hA5A5, "R9 super write scratch0");
    access(0, 1, 1, 2, 16'h5A5A, "R9 super write scratch1");
    access(1, 0, 0, 1, 0, "R6 user read restricted");
    // R6 privilege 0 opens the region
    access(0, 1, 1, 0, 16'h0000, "R6 clear privilege");
    access(1, 0, 0, 1, 0, "R6 user read open");
    access(0, 1, 0, 2, 16'h1111, "R6 user write open");
    access(1, 0, 1, 2, 0, "R6 readback user write");
    access(1, 0, 0, 0, 0, "R5 cfg still supervisor-only");

    // R7 unimplemented offsets
    for (int a = NSCR + 1; a < (1 << ADDR_W); a++) begin
      access(1, 0, 0, a, 0, "R7 user read unimpl");
      access(1, 0, 1, a, 0, "R7 super read unimpl");
      access(0, 1, 1, a, 16'hFFFF, "R7 super write unimpl");
    end
    access(1, 0, 1, 0, 0, "R7 cfg untouched");
    access(1, 0, 1, 1, 0, "R7 scratch0 untouched");
    access(1, 0, 1, 2, 0, "R7 scratch1 untouched");
    access(0, 0, 1, 0, 0, "R8 idle after");

    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule